// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Front End

This block is the synchronous front end of a separate-I/O, double-data-rate static memory. Each access moves one word of twice the bus width as two half-words on opposite clock edges. Commands are sampled on the rising edge of the input clock. A low command strobe selects an access, and the read/write level chooses its direction. A write collects its lower half-word at the next rising edge and its upper half-word at the falling edge after that. Each half-word carries its own byte-enable pair. The merged word is then committed to a small internal register array.

A read drives the lower half-word of the addressed location while the output clock is high in the cycle after the request. It drives the upper half-word while that clock is low. When no further read follows, the output bus is released at the next rising output edge. An output-enable qualifies the bus, since a synthesizable block cannot float a pin. A mode strap is captured while reset is held. It chooses whether the outputs are timed by the input clock itself or by a separate output clock. Commands may arrive on every rising edge, so reads and writes stream with no idle cycles.

Top module: `ddrb2_sram`

## Requirements
- R1: With `cmd_n` high at a rising `clk` edge, nothing happens whatever `rd_nwr`, `addr`, `wdata` and `wbe` carry: no location changes and no read data is driven.
- R2: `cmd_n` low with `rd_nwr` high at rising edge n requests a read. During the high phase of the output clock cycle that starts at edge n+1, `rdata` carries bits 17:0 of the location and `rdata_oe` is high. During the low phase of that cycle it carries bits 35:18.
- R3: `cmd_n` low with `rd_nwr` low at edge n requests a write. `wdata` at rising edge n+1 becomes bits 17:0 of the location. `wdata` at the falling edge that follows becomes bits 35:18.
- R4: In each half-word, `wbe[0]` enables bits 8:0 and `wbe[1]` enables bits 17:9. Each pair is sampled together with its half-word, and a low enable leaves that byte of the stored location unchanged.
- R5: A new command is accepted at every rising edge. Consecutive reads give a continuous output stream with `rdata_oe` staying high, and consecutive writes all land.
- R6: A read requested at the edge after a write to the same address returns the newly written data.
- R7: In any output cycle not started by a read request at the previous edge, `rdata_oe` is low from that rising output edge, and `rdata` is zero while `rdata_oe` is low.
- R8: `one_clk_mode` is captured only while `rst_n` is low. When captured as 1, the outputs are timed by `clk` and `oclk_in` is ignored. When captured as 0, the outputs are timed by `oclk_in`. Changing the strap after reset has no effect.
- R9: Reset (`rst_n` low) clears every location to zero, drives `rdata_oe` low and `rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; commands on rising edge, upper write half on falling edge |
| oclk_in | input | 1 | Separate output clock, used when the strap selects two-clock timing |
| rst_n | input | 1 | Active-low reset, asynchronous for state, strap captured while low |
| one_clk_mode | input | 1 | Strap: 1 times outputs from `clk` |
| cmd_n | input | 1 | Active-low command strobe |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Location address |
| wdata | input | 18 | Write half-word |
| wbe | input | 2 | Byte enables for the current half-word |
| rdata | output | 18 | Read half-word, zero when not enabled |
| rdata_oe | output | 1 | High while `rdata` carries valid read data |

## Verification
In single-clock mode, the assertions check on every cycle that a read request raises the output enable two edges later. They also check that a cycle with no read request lowers it, that a write request reaches the capture stage, that an all-masked commit leaves the location untouched, and that the captured strap never moves outside reset. Only the bench scenarios can show the data values. These include the half-word order on the bus, partial byte merges, read-after-write to the same address, and that idle strobes change nothing. The same holds for the effect of the strap, which the bench exercises by stopping the output clock in each mode.

// File: rtl/ddrb2_pkg.sv
package ddrb2_pkg;
  localparam int HALF_W = 18;
  localparam int BYTE_W = 9;
  localparam int NBYTE  = HALF_W / BYTE_W;
  localparam int WORD_W = 2 * HALF_W;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE} op_e;

  function automatic op_e decode_op(input logic strobe_n, input logic rd_level);
    if (strobe_n)      return OP_NONE;
    else if (rd_level) return OP_READ;
    else               return OP_WRITE;
  endfunction

  function automatic logic [HALF_W-1:0] merge_half(input logic [HALF_W-1:0] old_v,
                                                   input logic [HALF_W-1:0] new_v,
                                                   input logic [NBYTE-1:0]  en);
    logic [HALF_W-1:0] r;
    r = old_v;
    for (int b = 0; b < NBYTE; b++)
      if (en[b]) r[b*BYTE_W +: BYTE_W] = new_v[b*BYTE_W +: BYTE_W];
    return r;
  endfunction
endpackage

// File: rtl/ddrb2_cmd_decode.sv
module ddrb2_cmd_decode
  import ddrb2_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_n,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_pend,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_pend,
  output logic [ADDR_W-1:0] wr_addr
);
  op_e op_now;
  assign op_now = decode_op(cmd_n, rd_nwr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
      rd_addr <= '0;
      wr_addr <= '0;
    end else begin
      rd_pend <= (op_now == OP_READ);
      wr_pend <= (op_now == OP_WRITE);
      if (op_now == OP_READ)  rd_addr <= addr;
      if (op_now == OP_WRITE) wr_addr <= addr;
    end
  end
endmodule

// File: rtl/ddrb2_wr_capture.sv
module ddrb2_wr_capture
  import ddrb2_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pend,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wdata,
  input  logic [NBYTE-1:0]  wbe,
  output logic              cap_valid,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [HALF_W-1:0] cap_lo,
  output logic [NBYTE-1:0]  cap_be
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_addr  <= '0;
      cap_lo    <= '0;
      cap_be    <= '0;
    end else begin
      cap_valid <= wr_pend;
      if (wr_pend) begin
        cap_addr <= wr_addr;
        cap_lo   <= wdata;
        cap_be   <= wbe;
      end
    end
  end
endmodule

// File: rtl/ddrb2_array.sv
module ddrb2_array
  import ddrb2_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [HALF_W-1:0] lo_data,
  input  logic [NBYTE-1:0]  lo_be,
  input  logic [HALF_W-1:0] hi_data,
  input  logic [NBYTE-1:0]  hi_be,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rword
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] old_word;
  logic [WORD_W-1:0] new_word;

  assign old_word = mem[waddr];
  assign new_word = {merge_half(old_word[WORD_W-1:HALF_W], hi_data, hi_be),
                     merge_half(old_word[HALF_W-1:0], lo_data, lo_be)};

  // upper half arrives on the falling edge; commit the whole word there
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[waddr] <= new_word;
    end
  end

  assign rword = mem[raddr];

  AST_MASKED_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
    (commit && lo_be == '0 && hi_be == '0) |-> (new_word == old_word)); // R4
endmodule

// File: rtl/ddrb2_rd_out.sv
module ddrb2_rd_out
  import ddrb2_pkg::*;
(
  input  logic              oclk,
  input  logic              rst_n,
  input  logic              rd_pend,
  input  logic [WORD_W-1:0] rd_word,
  output logic [HALF_W-1:0] rdata,
  output logic              rdata_oe
);
  logic [WORD_W-1:0] word_q;
  logic [HALF_W-1:0] fall_q;
  logic              oe_q;

  always_ff @(posedge oclk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      word_q <= '0;
    end else begin
      oe_q   <= rd_pend;
      word_q <= rd_pend ? rd_word : '0;
    end
  end

  always_ff @(negedge oclk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= word_q[WORD_W-1:HALF_W];
  end

  assign rdata_oe = oe_q;
  assign rdata    = !oe_q ? '0 : (oclk ? word_q[HALF_W-1:0] : fall_q);
endmodule

// File: rtl/ddrb2_sram.sv
module ddrb2_sram
  import ddrb2_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              oclk_in,
  input  logic              rst_n,
  input  logic              one_clk_mode,
  input  logic              cmd_n,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wdata,
  input  logic [NBYTE-1:0]  wbe,
  output logic [HALF_W-1:0] rdata,
  output logic              rdata_oe
);
  logic              mode_q;
  logic              oclk;
  logic              rd_pend;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_pend;
  logic [ADDR_W-1:0] wr_addr;
  logic              cap_valid;
  logic [ADDR_W-1:0] cap_addr;
  logic [HALF_W-1:0] cap_lo;
  logic [NBYTE-1:0]  cap_be;
  logic [WORD_W-1:0] rd_word;

  // strap is loaded only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= one_clk_mode;
  end

  assign oclk = mode_q ? clk : oclk_in;

  ddrb2_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .rd_nwr(rd_nwr), .addr(addr),
    .rd_pend(rd_pend), .rd_addr(rd_addr), .wr_pend(wr_pend), .wr_addr(wr_addr)
  );

  ddrb2_wr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .wr_pend(wr_pend), .wr_addr(wr_addr),
    .wdata(wdata), .wbe(wbe), .cap_valid(cap_valid), .cap_addr(cap_addr),
    .cap_lo(cap_lo), .cap_be(cap_be)
  );

  ddrb2_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .commit(cap_valid), .waddr(cap_addr),
    .lo_data(cap_lo), .lo_be(cap_be), .hi_data(wdata), .hi_be(wbe),
    .raddr(rd_addr), .rword(rd_word)
  );

  ddrb2_rd_out u_out (
    .oclk(oclk), .rst_n(rst_n), .rd_pend(rd_pend), .rd_word(rd_word),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  AST_WR_REACHES_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_n && !rd_nwr) |=> ##1 cap_valid); // R3

  AST_RD_RAISES_OE: assert property (@(posedge clk) disable iff (!rst_n || !mode_q)
    (!cmd_n && rd_nwr) |=> ##1 rdata_oe); // R2

  AST_IDLE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n || !mode_q)
    (cmd_n || !rd_nwr) |=> ##1 !rdata_oe); // R7

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q)); // R8
endmodule

// File: tb/ddrb2_sram_test.sv
module ddrb2_sram_test;
  import ddrb2_pkg::*;

  localparam int AW = 4;
  localparam int NV = 20;

  // entry: [45:44] op (1 read, 2 write, 0 idle rw low, 3 idle rw high)
  //        [43:40] addr, [39:22] lower half, [21:20] lower enables,
  //        [19:2] upper half, [1:0] upper enables
  localparam logic [45:0] TBL [NV] = '{
    {2'd2, 4'd3,  18'h2AAAA, 2'b11, 18'h15555, 2'b11},  // 0  R3 full write
    {2'd1, 4'd3,  18'h00000, 2'b00, 18'h00000, 2'b00},  // 1  R6 read right after write
    {2'd2, 4'd3,  18'h00000, 2'b01, 18'h3FFFF, 2'b10},  // 2  R4 partial bytes
    {2'd1, 4'd3,  18'h00000, 2'b00, 18'h00000, 2'b00},  // 3  R4
    {2'd2, 4'd5,  18'h12345, 2'b11, 18'h0ABCD, 2'b11},  // 4  R5 write stream
    {2'd2, 4'd6,  18'h3C3C3, 2'b11, 18'h01234, 2'b11},  // 5  R5
    {2'd1, 4'd5,  18'h00000, 2'b00, 18'h00000, 2'b00},  // 6  R5 read stream
    {2'd1, 4'd6,  18'h00000, 2'b00, 18'h00000, 2'b00},  // 7  R5
    {2'd1, 4'd0,  18'h00000, 2'b00, 18'h00000, 2'b00},  // 8  R9 cleared location
    {2'd0, 4'd5,  18'h3FFFF, 2'b11, 18'h3FFFF, 2'b11},  // 9  R1 idle, rw low
    {2'd2, 4'd7,  18'h11111, 2'b00, 18'h22222, 2'b00},  // 10 R4 all masked
    {2'd1, 4'd7,  18'h00000, 2'b00, 18'h00000, 2'b00},  // 11 R4
    {2'd3, 4'd6,  18'h3FFFF, 2'b11, 18'h3FFFF, 2'b11},  // 12 R1 idle, rw high
    {2'd1, 4'd5,  18'h00000, 2'b00, 18'h00000, 2'b00},  // 13 R1 unchanged
    {2'd2, 4'd15, 18'h3FE00, 2'b10, 18'h001FF, 2'b01},  // 14 R4 top address
    {2'd1, 4'd15, 18'h00000, 2'b00, 18'h00000, 2'b00},  // 15 R4
    {2'd2, 4'd9,  18'h1F0F0, 2'b11, 18'h20F0F, 2'b11},  // 16 R8 two-clock mode
    {2'd1, 4'd9,  18'h00000, 2'b00, 18'h00000, 2'b00},  // 17 R8
    {2'd1, 4'd9,  18'h00000, 2'b00, 18'h00000, 2'b00},  // 18 R8
    {2'd0, 4'd0,  18'h00000, 2'b00, 18'h00000, 2'b00}   // 19 R8
  };
  localparam int TAG [NV] = '{3, 6, 4, 4, 5, 5, 5, 5, 9, 1, 4, 4, 1, 1, 4, 4, 8, 8, 8, 8};

  logic              clk = 1'b0;
  logic              oclk_in = 1'b0;
  logic              oclk_run = 1'b0;
  logic              rst_n = 1'b0;
  logic              one_clk_mode = 1'b1;
  logic              cmd_n = 1'b1;
  logic              rd_nwr = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [HALF_W-1:0] wdata = '0;
  logic [NBYTE-1:0]  wbe = '0;
  logic [HALF_W-1:0] rdata;
  logic              rdata_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [WORD_W-1:0] refm [1 << AW];
  logic [WORD_W-1:0] expw [NV];

  ddrb2_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .oclk_in(oclk_in), .rst_n(rst_n), .one_clk_mode(one_clk_mode),
    .cmd_n(cmd_n), .rd_nwr(rd_nwr), .addr(addr), .wdata(wdata), .wbe(wbe),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  initial begin
    forever begin
      #10;
      clk = ~clk;
      oclk_in = oclk_run ? clk : 1'b0;
    end
  end

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [HALF_W-1:0] bench_merge(input logic [HALF_W-1:0] o,
                                                    input logic [HALF_W-1:0] n,
                                                    input logic [1:0] en);
    logic [HALF_W-1:0] m;
    m = {{9{en[1]}}, {9{en[0]}}};
    return (o & ~m) | (n & m);
  endfunction

  task automatic set_ctrl(input int j);
    logic [45:0] e;
    logic [AW-1:0] a;
    e = TBL[j];
    a = e[43:40];
    cmd_n  = !(e[45:44] == 2'd1 || e[45:44] == 2'd2);
    rd_nwr = e[44];
    addr   = a;
    if (e[45:44] == 2'd2)
      refm[a] = {bench_merge(refm[a][35:18], e[19:2], e[1:0]),
                 bench_merge(refm[a][17:0], e[39:22], e[21:20])};
    if (e[45:44] == 2'd1) expw[j] = refm[a];
  endtask

  // entered at a rising edge + 15
  task automatic run_seq(input int first, input int last);
    set_ctrl(first);
    for (int t = first; t <= last + 1; t++) begin
      logic [45:0] pe;
      bit pv;
      bit prd;
      pv  = (t - 1 >= first);
      pe  = pv ? TBL[t-1] : '0;
      prd = pv && (pe[45:44] == 2'd1);
      @(posedge clk); #5;
      chk(prd ? "R2 oe" : "R7 oe", {35'd0, rdata_oe}, {35'd0, prd});
      if (prd) chk($sformatf("R%0d low half", TAG[t-1]), {18'd0, rdata}, {18'd0, expw[t-1][17:0]});
      if (!prd) chk("R7 bus zero", {18'd0, rdata}, 36'd0);
      if (pv && pe[45:44] != 2'd1) begin
        wdata = pe[19:2];
        wbe   = pe[1:0];
      end
      #10;
      if (prd) chk($sformatf("R%0d high half", TAG[t-1]), {18'd0, rdata}, {18'd0, expw[t-1][35:18]});
      if (t + 1 <= last) set_ctrl(t + 1);
      else begin
        cmd_n  = 1'b1;
        rd_nwr = 1'b0;
      end
      if (t <= last) begin
        wdata = TBL[t][39:22];
        wbe   = TBL[t][21:20];
      end else begin
        wdata = '0;
        wbe   = '0;
      end
    end
  endtask

  // leaves time at a rising edge + 15
  task automatic do_reset(input logic mode, input logic run_oc);
    rst_n = 1'b0;
    cmd_n = 1'b1;
    rd_nwr = 1'b0;
    one_clk_mode = mode;
    oclk_run = run_oc;
    repeat (3) @(posedge clk);
    #15;
    rst_n = 1'b1;
    for (int i = 0; i < (1 << AW); i++) refm[i] = '0;
    @(posedge clk); #5;
    chk("R9 oe after reset", {35'd0, rdata_oe}, 36'd0);
    chk("R9 data after reset", {18'd0, rdata}, 36'd0);
    #10;
  endtask

  initial begin
    // single-clock mode with the output clock stopped; strap moved after reset
    do_reset(1'b1, 1'b0);
    one_clk_mode = 1'b0;      // R8: must have no effect now
    run_seq(0, 15);

    // two-clock mode, output clock running in phase
    do_reset(1'b0, 1'b1);
    run_seq(16, 19);

    // two-clock mode with the output clock stopped: read must not appear (R8)
    oclk_run = 1'b0;
    cmd_n = 1'b0;
    rd_nwr = 1'b1;
    addr = 4'd9;
    @(posedge clk); #15;
    cmd_n = 1'b1;
    @(posedge clk); #5;
    chk("R8 stopped output clock oe", {35'd0, rdata_oe}, 36'd0);
    #10;
    chk("R8 stopped output clock data", {18'd0, rdata}, 36'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule